// File: doc/BRIEF.md
# Dual-Bank Interrupt Routing Controller

This block gathers 40 level-sensitive interrupt lines into two 32-bit banks. Bank 0 holds lines 0 to 31 and bank 1 holds lines 32 to 39 in its low eight bits. Each clock the block samples every line into a pending bit. A per-line enable mask and a per-line routing bit then decide whether a pending line drives the fast interrupt output (FIQ) or the normal interrupt output (IRQ).

While the processor is halted, a wake output can pull it back out. A control bit selects the wake policy. Under one policy only enabled lines can wake the core. Under the other, any pending line can, even when it is masked.

Software reaches the enable, routing and control state through a word-addressed read/write port. Reads are combinational. The port also gives filtered views of the pending state. The masked pending vector and the routing vector leave the block as plain outputs, so that a separate priority resolver can use them.

Top module: `irq_route_ctrl`

## Requirements
- R1: There are 40 lines. Line n (n<32) sits in bank 0 at bit n, and line 32+k sits in bank 1 at bit k. The byte offsets per bank are: IRQ view (bank 0 0x00, bank 1 0x9C), enable (0x04 / 0xA0), routing (0x08 / 0xA4), FIQ view (0x0C / 0xA8) and raw pending (0x10 / 0xAC). The control register sits at 0x14.
- R2: At each rising clock edge, a line's pending bit takes the line's level. A raw pending read returns the pending bits with no mask applied.
- R3: A routing bit of 1 sends a line to FIQ and 0 sends it to IRQ. fiq_o is high when any line is pending, enabled and routed to FIQ, and irq_o follows the same rule for lines routed to IRQ. Both outputs are registered. A line rising ahead of edge k sets pending at edge k and sets the output at edge k+1.
- R4: The enable and routing registers read back what was written. Bits 8 to 31 of every bank 1 register read as zero.
- R5: The IRQ view reads pending AND enable AND NOT routing. The FIQ view reads pending AND enable AND routing.
- R6: Writing 1 to control bit 0 limits wake to enabled lines, and writing 0 lets any pending line wake the core. A control read returns 1 only under the limited policy. The reset value is 0.
- R7: wake_o is registered. It is high only when halted_i was high at the sampling edge and pending AND (enable OR all-lines policy) is nonzero in either bank.
- R8: After reset, the pending, enable and routing registers are zero, and so are fiq_o, irq_o and wake_o.
- R9: An unmapped or unaligned offset reads zero, and a write to it changes nothing. Writes to the view and raw pending offsets change nothing.
- R10: masked_pend_o equals pending AND enable over all 40 lines, and route_o equals the routing register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 40 | Interrupt line levels |
| halted_i | input | 1 | Processor is halted |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request to halted core |
| masked_pend_o | output | 40 | Pending AND enable, to priority resolver |
| route_o | output | 40 | Routing vector, to priority resolver |

## Verification
The hardest case to reach is wake caused by a line that is masked. It needs three things at once: a pending line whose enable bit is clear, the all-lines policy, and halted_i high. None of these shows on fiq_o or irq_o. The bench first clears every enable bit and raises one line. It then asserts halted_i and toggles the control bit, and checks that wake_o follows the policy while both interrupt outputs stay low. Bank 1's narrow width is covered by writing all ones to its registers and reading back only the low eight bits.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int DW    = 32;
  localparam int AW    = 8;
  localparam int BASE0 = 'h00;
  localparam int BASE1 = 'h9C;
  localparam int NREG  = 5;   // per-bank registers before control

  typedef enum logic [2:0] {
    RG_IVIEW = 3'd0,
    RG_EN    = 3'd1,
    RG_ROUTE = 3'd2,
    RG_FVIEW = 3'd3,
    RG_RAW   = 3'd4,
    RG_CTRL  = 3'd5,
    RG_NONE  = 3'd7
  } reg_e;

  typedef struct packed {
    logic       hit;
    logic       bank;
    reg_e       sel;
  } dec_t;

  // Byte offset to register selector; unaligned or unlisted offsets miss.
  function automatic dec_t decode(input logic [AW-1:0] a);
    dec_t d;
    int   off;
    d   = '{hit: 1'b0, bank: 1'b0, sel: RG_NONE};
    off = int'(a);
    if (a[1:0] == 2'b00) begin
      if (off <= BASE0 + 4*NREG) begin
        d.hit = 1'b1;
        d.sel = reg_e'(3'((off - BASE0) >> 2));
      end else if (off >= BASE1 && off < BASE1 + 4*NREG) begin
        d.hit  = 1'b1;
        d.bank = 1'b1;
        d.sel  = reg_e'(3'((off - BASE1) >> 2));
      end
    end
    return d;
  endfunction

  // Filtered pending view: routed-to-fast or routed-to-normal.
  function automatic logic [DW-1:0] pend_view(input logic [DW-1:0] pend,
                                               input logic [DW-1:0] en,
                                               input logic [DW-1:0] route,
                                               input logic fast);
    return pend & en & (fast ? route : ~route);
  endfunction

  // Wake candidate bits under the chosen idle policy.
  function automatic logic [DW-1:0] wake_bits(input logic [DW-1:0] pend,
                                               input logic [DW-1:0] en,
                                               input logic all_lines);
    return pend & (en | {DW{all_lines}});
  endfunction
endpackage

// File: rtl/irc_bank.sv
module irc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  input  logic         en_we_i,
  input  logic         route_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         all_lines_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] route_o,
  output logic         fast_hit_o,
  output logic         norm_hit_o,
  output logic         wake_hit_o
);
  import irc_pkg::*;

  logic [W-1:0] pend_q, en_q, route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
    end else begin
      pend_q <= line_i;
      if (en_we_i)    en_q    <= wdata_i;
      if (route_we_i) route_q <= wdata_i;
    end
  end

  logic [DW-1:0] pend_x, en_x, route_x;
  assign pend_x  = DW'(pend_q);
  assign en_x    = DW'(en_q);
  assign route_x = DW'(route_q);

  assign fast_hit_o = |pend_view(pend_x, en_x, route_x, 1'b1);
  assign norm_hit_o = |pend_view(pend_x, en_x, route_x, 1'b0);
  assign wake_hit_o = |wake_bits(pend_x, en_x, all_lines_i);

  assign pend_o  = pend_q;
  assign en_o    = en_q;
  assign route_o = route_q;

  AST_PEND_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend_q == $past(line_i)); // R2
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(en_we_i) |-> en_q == $past(wdata_i)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(en_we_i) |-> $stable(en_q)); // R9
  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(route_we_i) |-> $stable(route_q)); // R9
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int NSRC = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] line_i,
  input  logic            halted_i,
  input  logic            wr_en_i,
  input  logic [7:0]      addr_i,
  input  logic [31:0]     wr_data_i,
  output logic [31:0]     rd_data_o,
  output logic            fiq_o,
  output logic            irq_o,
  output logic            wake_o,
  output logic [NSRC-1:0] masked_pend_o,
  output logic [NSRC-1:0] route_o
);
  import irc_pkg::*;

  localparam int NBANK = 2;

  dec_t dec;
  assign dec = decode(addr_i);

  logic idle_lim_q;
  logic all_lines;
  assign all_lines = ~idle_lim_q;

  logic [DW-1:0] b_pend [NBANK];
  logic [DW-1:0] b_en   [NBANK];
  logic [DW-1:0] b_route[NBANK];
  logic [NBANK-1:0] fast_hit, norm_hit, wake_hit;
  logic [NSRC-1:0] pend_all, en_all, route_all;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO = b * DW;
    localparam int W  = (b == 0) ? DW : NSRC - DW;
    logic [W-1:0] pend_w, en_w, route_w;
    logic en_we, route_we;
    assign en_we    = wr_en_i && dec.hit && dec.bank == 1'(b) && dec.sel == RG_EN;
    assign route_we = wr_en_i && dec.hit && dec.bank == 1'(b) && dec.sel == RG_ROUTE;

    irc_bank #(.W(W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i[LO +: W]),
      .en_we_i    (en_we),
      .route_we_i (route_we),
      .wdata_i    (wr_data_i[W-1:0]),
      .all_lines_i(all_lines),
      .pend_o     (pend_w),
      .en_o       (en_w),
      .route_o    (route_w),
      .fast_hit_o (fast_hit[b]),
      .norm_hit_o (norm_hit[b]),
      .wake_hit_o (wake_hit[b])
    );

    assign b_pend[b]  = DW'(pend_w);
    assign b_en[b]    = DW'(en_w);
    assign b_route[b] = DW'(route_w);
    assign pend_all[LO +: W]  = pend_w;
    assign en_all[LO +: W]    = en_w;
    assign route_all[LO +: W] = route_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_lim_q <= 1'b0;
      fiq_o      <= 1'b0;
      irq_o      <= 1'b0;
      wake_o     <= 1'b0;
    end else begin
      if (wr_en_i && dec.hit && dec.sel == RG_CTRL) idle_lim_q <= wr_data_i[0];
      fiq_o  <= |fast_hit;
      irq_o  <= |norm_hit;
      wake_o <= halted_i && (|wake_hit);
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (dec.hit) begin
      case (dec.sel)
        RG_IVIEW: rd_data_o = pend_view(b_pend[dec.bank], b_en[dec.bank], b_route[dec.bank], 1'b0);
        RG_FVIEW: rd_data_o = pend_view(b_pend[dec.bank], b_en[dec.bank], b_route[dec.bank], 1'b1);
        RG_EN:    rd_data_o = b_en[dec.bank];
        RG_ROUTE: rd_data_o = b_route[dec.bank];
        RG_RAW:   rd_data_o = b_pend[dec.bank];
        RG_CTRL:  rd_data_o = {31'd0, idle_lim_q};
        default:  rd_data_o = '0;
      endcase
    end
  end

  assign masked_pend_o = pend_all & en_all;
  assign route_o       = route_all;

  // Named events for the checks below.
  logic fast_cause, norm_cause, b1_read;
  assign fast_cause = |(pend_all & en_all & route_all);
  assign norm_cause = |(pend_all & en_all & ~route_all);
  assign b1_read    = dec.hit && dec.bank;

  AST_FIQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> fiq_o == $past(fast_cause)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_o == $past(norm_cause)); // R3
  AST_WAKE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && wake_o |-> $past(halted_i)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.hit |-> rd_data_o == '0); // R9
  AST_B1_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    b1_read |-> rd_data_o[31:8] == '0); // R4
  AST_EXPORT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_pend_o & ~pend_all) == '0); // R10
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] line_i = '0;
  logic        halted_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        fiq_o, irq_o, wake_o;
  logic [39:0] masked_pend_o, route_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_route_ctrl u_dut (.*);

  typedef struct packed {
    logic [39:0] src;
    logic [39:0] en;
    logic [39:0] rt;
    logic        fiq;
    logic        irq;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{40'h00_0000_0001, 40'h00_0000_0001, 40'h00_0000_0000, 1'b0, 1'b1},
    '{40'h00_0000_0001, 40'h00_0000_0001, 40'h00_0000_0001, 1'b1, 1'b0},
    '{40'h08_0000_0000, 40'h08_0000_0000, 40'h08_0000_0000, 1'b1, 1'b0},
    '{40'h80_0000_0000, 40'h00_0000_0000, 40'h00_0000_0000, 1'b0, 1'b0},
    '{40'hFF_0000_0003, 40'h80_0000_0002, 40'h80_0000_0000, 1'b1, 1'b1},
    '{40'h00_0000_0000, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic set_en(input logic [39:0] v);
    wr(8'h04, v[31:0]);
    wr(8'hA0, {24'd0, v[39:32]});
  endtask

  task automatic set_rt(input logic [39:0] v);
    wr(8'h08, v[31:0]);
    wr(8'hA4, {24'd0, v[39:32]});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [39:0] iv, fv;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 fiq", {39'd0, fiq_o}, 40'd0);
    chk("R8 irq", {39'd0, irq_o}, 40'd0);
    chk("R8 wake", {39'd0, wake_o}, 40'd0);
    rd(8'h04, d); chk("R8 enable", {8'd0, d}, 40'd0);
    rd(8'h08, d); chk("R8 routing", {8'd0, d}, 40'd0);
    rd(8'h14, d); chk("R6 control reset", {8'd0, d}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 R10: table walk
    for (int i = 0; i < 6; i++) begin
      set_en(TBL[i].en);
      set_rt(TBL[i].rt);
      line_i = TBL[i].src;
      repeat (3) @(negedge clk);
      chk("R3 fiq", {39'd0, fiq_o}, {39'd0, TBL[i].fiq});
      chk("R3 irq", {39'd0, irq_o}, {39'd0, TBL[i].irq});
      iv = TBL[i].src & TBL[i].en & ~TBL[i].rt;
      fv = TBL[i].src & TBL[i].en & TBL[i].rt;
      rd(8'h00, d); chk("R5 irq view b0", {8'd0, d}, {8'd0, iv[31:0]});
      rd(8'h9C, d); chk("R5 irq view b1", {8'd0, d}, {32'd0, iv[39:32]});
      rd(8'h0C, d); chk("R5 fiq view b0", {8'd0, d}, {8'd0, fv[31:0]});
      rd(8'hA8, d); chk("R5 fiq view b1", {8'd0, d}, {32'd0, fv[39:32]});
      rd(8'h10, d); chk("R2 raw b0", {8'd0, d}, {8'd0, TBL[i].src[31:0]});
      rd(8'hAC, d); chk("R1 raw b1", {8'd0, d}, {32'd0, TBL[i].src[39:32]});
      chk("R10 masked", masked_pend_o, TBL[i].src & TBL[i].en);
      chk("R10 route", route_o, TBL[i].rt);
    end

    // R3: latency from line edge
    set_en(40'h1); set_rt(40'h0); line_i = '0;
    repeat (2) @(negedge clk);
    line_i = 40'h1;
    @(negedge clk);
    chk("R3 latency one edge", {39'd0, irq_o}, 40'd0);
    @(negedge clk);
    chk("R3 latency two edges", {39'd0, irq_o}, 40'd1);

    // R4: bank 1 width, readback
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, d); chk("R4 bank1 upper zero", {8'd0, d}, 40'h0000_00FF);
    wr(8'h08, 32'hA5A5_5A5A);
    rd(8'h08, d); chk("R4 routing readback", {8'd0, d}, 40'hA5A5_5A5A);

    // R9: unwritable and unmapped
    line_i = '0;
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R9 raw unwritable", {8'd0, d}, 40'd0);
    wr(8'h04, 32'h0000_1234);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R9 unmapped write", {8'd0, d}, 40'h0000_1234);
    rd(8'h18, d); chk("R9 unmapped read", {8'd0, d}, 40'd0);
    rd(8'h05, d); chk("R9 unaligned read", {8'd0, d}, 40'd0);
    rd(8'hB0, d); chk("R9 past bank1", {8'd0, d}, 40'd0);

    // R6 R7: wake policy with masked line
    set_en(40'h0); set_rt(40'h0);
    line_i = 40'h20;
    halted_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 wake masked all-lines", {39'd0, wake_o}, 40'd1);
    chk("R7 irq stays low", {39'd0, irq_o}, 40'd0);
    wr(8'h14, 32'h1);
    rd(8'h14, d); chk("R6 control read", {8'd0, d}, 40'd1);
    @(negedge clk);
    chk("R6 wake limited", {39'd0, wake_o}, 40'd0);
    set_en(40'h20);
    @(negedge clk);
    chk("R7 wake enabled", {39'd0, wake_o}, 40'd1);
    halted_i = 1'b0;
    @(negedge clk);
    chk("R7 not halted", {39'd0, wake_o}, 40'd0);
    wr(8'h14, 32'h0);
    line_i = 40'h80_0000_0000; set_en(40'h0); halted_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 wake bank1 masked", {39'd0, wake_o}, 40'd1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule